// File: doc/BRIEF.md
# Exception Return Checker and Frame Unstacker

This unit completes the return from an exception handler on a small microcontroller core. When the core branches to one of the special return values while in handler mode, it presents that value, its instruction-set state flag, the number of the exception being left, and the answer the interrupt controller gave to a query about nesting. The unit forms a return code from these inputs and checks that the return is legal. A legal return pops the eight-word saved frame from the chosen stack over a simple 32-bit read port. The unit then writes the values back to the register file and checks that the restored mode matches the mode the return code asked for.

Either check can fail. The first check runs before any memory traffic, and a failure there leaves the existing frame in place. The second runs after the pop, and a failure there requires a fresh frame to be pushed. In both cases the unit raises an invalid-PC usage fault and hands a link value to the exception entry sequencer. Each request ends in exactly one one-cycle pulse, either `ret_done` or `ret_fault`.

The controller has eight states:
- ST_IDLE: waits for a request.
- ST_CHECK: runs the pre-pop check.
- ST_FAULT_OLD: reports a pre-pop fault.
- ST_POP_REQ: issues a read.
- ST_POP_WAIT: waits for the read data.
- ST_MODE: restores the stack pointer and runs the mode check.
- ST_FAULT_NEW: reports a post-pop fault.
- ST_DONE: reports success.

Its transitions are:
- IDLE to CHECK on a request.
- CHECK to FAULT_OLD on a pre-pop fault; CHECK to POP_REQ otherwise.
- POP_REQ to POP_WAIT.
- POP_WAIT to POP_REQ when read data arrives and words remain; POP_WAIT to MODE when the eighth word arrives.
- MODE to FAULT_NEW on a mode mismatch; MODE to DONE otherwise.
- FAULT_OLD, FAULT_NEW and DONE back to IDLE.

Top module: `exc_return_unit`

## Requirements
- R1: The return code is the target value with its bit 0 ORed with `isa_flag`. A target ending in 0x8 presented with `isa_flag`=0 therefore has low nibble 0x8 and is a fault.
- R2: `hibits_warn` pulses in ST_CHECK when bits [27:5] of the return code are not all ones. Processing then continues unchanged.
- R3: `faultmask_clr` pulses in ST_CHECK for every request whose exception number is not the NMI number (2). For NMI it stays low.
- R4: `nest_status` is encoded as follows:
  - 2'b00: another exception is still active.
  - 2'b01: the return is to base level.
  - Any other value: the exiting exception was not active, which is a pre-pop fault.
- R5: The low nibble of the return code selects the target:
  - 0x1: handler mode.
  - 0x9: thread mode on the main stack (`msp_in`).
  - 0xD: thread mode on the process stack (`psp_in`).
  - Any other nibble: a pre-pop fault.
  
  `sp_proc_sel` is 1 exactly for 0xD.
- R6: A thread-mode return whose nest status is not 2'b01 is a pre-pop fault, unless `nonbase_thread_en` is 1.
- R7: On a pre-pop fault the unit performs no memory reads. It pulses `ret_fault`, `invpc_set` and `usage_pend` with `fault_new_frame`=0. During that pulse `link_value` equals the return code OR 0xF0000000.
- R8: A legal return issues eight one-cycle reads at stack base, +4, +8, and so on. Each read word is written out with `reg_idx` 0 to 7 in pop order: R0, R1, R2, R3, R12, LR, PC, xPSR.
- R9: After the eighth word, `sp_we` pulses with `sp_wdata` = base+32, ORed with 4 when bit 9 of the popped xPSR is 1. A success follows in the next cycle.
- R10: After the pop the mode check fails in two cases: handler mode was requested and xPSR[8:0] is 0, or thread mode was requested and xPSR[8:0] is nonzero. On failure the unit pulses `ret_fault`, `invpc_set` and `usage_pend` with `fault_new_frame`=1 and the same link value as R7.
- R11: Every request yields exactly one one-cycle pulse, either `ret_done` or `ret_fault`, and never both.
- R12: During and after reset all pulse and request outputs are 0. A reset in mid-pop returns the unit to ST_IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ret_req | input | 1 | Return request, sampled in ST_IDLE |
| ret_target | input | 32 | Branch target value |
| isa_flag | input | 1 | Instruction-set state flag, supplies bit 0 |
| cur_exc | input | 9 | Number of the exception being exited |
| nest_status | input | 2 | Nesting answer from the interrupt controller |
| nonbase_thread_en | input | 1 | Allows thread return while nested |
| msp_in | input | 32 | Main stack pointer |
| psp_in | input | 32 | Process stack pointer |
| mem_req | output | 1 | Read request pulse |
| mem_addr | output | 32 | Read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| reg_we | output | 1 | Restored register write strobe |
| reg_idx | output | 3 | Pop position of the word being written |
| reg_wdata | output | 32 | Restored register value |
| sp_we | output | 1 | Stack pointer write strobe |
| sp_proc_sel | output | 1 | 1 selects the process stack |
| sp_wdata | output | 32 | Restored stack pointer |
| faultmask_clr | output | 1 | Clear the fault mask |
| hibits_warn | output | 1 | Diagnostic: high bits of the return code not all ones |
| ret_done | output | 1 | Successful return pulse |
| ret_fault | output | 1 | Failed return pulse |
| fault_new_frame | output | 1 | With ret_fault: a new frame must be pushed |
| invpc_set | output | 1 | Set the invalid-PC fault status bit |
| usage_pend | output | 1 | Pend a usage fault |
| link_value | output | 32 | Link value for the entry sequencer |

## Verification
On every cycle the assertions check four things: `ret_done` and `ret_fault` never coincide, each read request lasts one cycle, a stack-pointer restore is always followed by an outcome (a success or a new-frame fault), and every success is preceded by a restore. Some behaviours can only be shown by the bench's scenarios, because they depend on the values of whole requests:
- which nibble, nesting and enable combinations fault, and at which of the two checks;
- the exact link value;
- the read addresses and the pop order;
- the alignment adjustment of the restored stack pointer;
- the diagnostic and fault-mask pulses.

// File: rtl/erx_pkg.sv
package erx_pkg;

    localparam int FRAME_WORDS = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CHECK,
        ST_FAULT_OLD,
        ST_POP_REQ,
        ST_POP_WAIT,
        ST_MODE,
        ST_FAULT_NEW,
        ST_DONE
    } erx_state_e;

    typedef enum logic [1:0] {
        TGT_HANDLER,
        TGT_THREAD_MAIN,
        TGT_THREAD_PROC,
        TGT_BAD
    } erx_target_e;

    localparam logic [1:0] NEST_STILL = 2'b00;
    localparam logic [1:0] NEST_BASE  = 2'b01;

endpackage

// File: rtl/erx_decode.sv
module erx_decode
    import erx_pkg::*;
#(
    parameter int DW      = 32,
    parameter int EXC_W   = 9,
    parameter int NMI_NUM = 2
) (
    input  logic [DW-1:0]    code,
    input  logic [EXC_W-1:0] exc,
    input  logic [1:0]       nest,
    input  logic             nonbase_en,
    output erx_target_e      target,
    output logic             prefault,
    output logic             hibits_low,
    output logic             fm_clear
);

    logic not_active;
    logic to_thread;

    always_comb begin
        unique case (code[3:0])
            4'h1:    target = TGT_HANDLER;
            4'h9:    target = TGT_THREAD_MAIN;
            4'hD:    target = TGT_THREAD_PROC;
            default: target = TGT_BAD;
        endcase
        hibits_low = (code[27:5] != '1);
        fm_clear   = (exc != EXC_W'(NMI_NUM));
        not_active = !((nest == NEST_STILL) || (nest == NEST_BASE));
        to_thread  = (target == TGT_THREAD_MAIN) || (target == TGT_THREAD_PROC);
        prefault   = not_active
                   || (target == TGT_BAD)
                   || (to_thread && (nest != NEST_BASE) && !nonbase_en);
    end

endmodule

// File: rtl/erx_frame_ctr.sv
module erx_frame_ctr #(
    parameter int DW    = 32,
    parameter int WORDS = 8,
    localparam int IW   = $clog2(WORDS),
    localparam int STEP = DW / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_sp,
    input  logic          step,
    output logic [DW-1:0] sp,
    output logic [IW-1:0] idx,
    output logic          last
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp  <= '0;
            idx <= '0;
        end else if (load) begin
            sp  <= load_sp;
            idx <= '0;
        end else if (step) begin
            sp  <= sp + DW'(STEP);
            idx <= idx + 1'b1;
        end
    end

    assign last = (idx == IW'(WORDS - 1));

endmodule

// File: rtl/exc_return_unit.sv
module exc_return_unit
    import erx_pkg::*;
#(
    parameter int DW      = 32,
    parameter int EXC_W   = 9,
    parameter int NMI_NUM = 2,
    localparam int IW     = $clog2(FRAME_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ret_req,
    input  logic [DW-1:0]    ret_target,
    input  logic             isa_flag,
    input  logic [EXC_W-1:0] cur_exc,
    input  logic [1:0]       nest_status,
    input  logic             nonbase_thread_en,
    input  logic [DW-1:0]    msp_in,
    input  logic [DW-1:0]    psp_in,
    output logic             mem_req,
    output logic [DW-1:0]    mem_addr,
    input  logic             mem_rvalid,
    input  logic [DW-1:0]    mem_rdata,
    output logic             reg_we,
    output logic [IW-1:0]    reg_idx,
    output logic [DW-1:0]    reg_wdata,
    output logic             sp_we,
    output logic             sp_proc_sel,
    output logic [DW-1:0]    sp_wdata,
    output logic             faultmask_clr,
    output logic             hibits_warn,
    output logic             ret_done,
    output logic             ret_fault,
    output logic             fault_new_frame,
    output logic             invpc_set,
    output logic             usage_pend,
    output logic [DW-1:0]    link_value
);

    localparam logic [DW-1:0] LINK_HI = {4'hF, {(DW-4){1'b0}}};
    localparam logic [DW-1:0] ALIGN_ADJ = DW'(4);

    erx_state_e        state, nxt;
    logic [DW-1:0]     code_q;
    logic [EXC_W-1:0]  exc_q;
    logic [1:0]        nest_q;
    logic              en_q;
    logic [EXC_W-1:0]  xpsr_exc_q;
    logic              xpsr_align_q;

    erx_target_e       target;
    logic              prefault, hibits_low, fm_clear;
    logic [DW-1:0]     sp_cur;
    logic [IW-1:0]     idx;
    logic              last;
    logic              ctr_load, ctr_step, mode_bad;

    erx_decode #(.DW(DW), .EXC_W(EXC_W), .NMI_NUM(NMI_NUM)) i_decode (
        .code       (code_q),
        .exc        (exc_q),
        .nest       (nest_q),
        .nonbase_en (en_q),
        .target     (target),
        .prefault   (prefault),
        .hibits_low (hibits_low),
        .fm_clear   (fm_clear)
    );

    assign ctr_load = (state == ST_CHECK) && !prefault;
    assign ctr_step = (state == ST_POP_WAIT) && mem_rvalid;

    erx_frame_ctr #(.DW(DW), .WORDS(FRAME_WORDS)) i_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (ctr_load),
        .load_sp ((target == TGT_THREAD_PROC) ? psp_in : msp_in),
        .step    (ctr_step),
        .sp      (sp_cur),
        .idx     (idx),
        .last    (last)
    );

    assign mode_bad = ((target == TGT_HANDLER) == (xpsr_exc_q == '0));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // captured request and popped status word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q       <= '0;
            exc_q        <= '0;
            nest_q       <= '0;
            en_q         <= 1'b0;
            xpsr_exc_q   <= '0;
            xpsr_align_q <= 1'b0;
        end else begin
            if ((state == ST_IDLE) && ret_req) begin
                code_q <= ret_target | DW'(isa_flag);
                exc_q  <= cur_exc;
                nest_q <= nest_status;
                en_q   <= nonbase_thread_en;
            end
            if (ctr_step && last) begin
                xpsr_exc_q   <= mem_rdata[EXC_W-1:0];
                xpsr_align_q <= mem_rdata[9];
            end
        end
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:      if (ret_req) nxt = ST_CHECK;
            ST_CHECK:     nxt = prefault ? ST_FAULT_OLD : ST_POP_REQ;
            ST_POP_REQ:   nxt = ST_POP_WAIT;
            ST_POP_WAIT:  if (mem_rvalid) nxt = last ? ST_MODE : ST_POP_REQ;
            ST_MODE:      nxt = mode_bad ? ST_FAULT_NEW : ST_DONE;
            ST_FAULT_OLD: nxt = ST_IDLE;
            ST_FAULT_NEW: nxt = ST_IDLE;
            ST_DONE:      nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_req         = 1'b0;
        reg_we          = 1'b0;
        sp_we           = 1'b0;
        faultmask_clr   = 1'b0;
        hibits_warn     = 1'b0;
        ret_done        = 1'b0;
        ret_fault       = 1'b0;
        fault_new_frame = 1'b0;
        invpc_set       = 1'b0;
        usage_pend      = 1'b0;
        mem_addr        = sp_cur;
        reg_idx         = idx;
        reg_wdata       = mem_rdata;
        sp_proc_sel     = (target == TGT_THREAD_PROC);
        sp_wdata        = sp_cur | (xpsr_align_q ? ALIGN_ADJ : '0);
        link_value      = code_q | LINK_HI;
        unique case (state)
            ST_IDLE: ;
            ST_CHECK: begin
                faultmask_clr = fm_clear;
                hibits_warn   = hibits_low;
            end
            ST_POP_REQ:  mem_req = 1'b1;
            ST_POP_WAIT: reg_we  = mem_rvalid;
            ST_MODE:     sp_we   = 1'b1;
            ST_FAULT_OLD: begin
                ret_fault  = 1'b1;
                invpc_set  = 1'b1;
                usage_pend = 1'b1;
            end
            ST_FAULT_NEW: begin
                ret_fault       = 1'b1;
                fault_new_frame = 1'b1;
                invpc_set       = 1'b1;
                usage_pend      = 1'b1;
            end
            ST_DONE: ret_done = 1'b1;
        endcase
    end

    // R11
    single_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ret_done && ret_fault));

    // R8
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // R10
    restore_to_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sp_we |=> (ret_done || (ret_fault && fault_new_frame)));

    // R9
    done_after_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_done |-> $past(sp_we));

endmodule

// File: tb/test_exc_return_unit.sv
`timescale 1ns/1ps
module test_exc_return_unit;

    localparam logic [31:0] MSP = 32'h2000_1000;
    localparam logic [31:0] PSP = 32'h2000_2000;

    typedef struct packed {
        logic [31:0] tgt;
        logic        isa;
        logic [8:0]  exc;
        logic [1:0]  nest;
        logic        en;
        logic [8:0]  field;
        logic        align;
        logic [1:0]  kind;   // 0 done, 1 pre-pop fault, 2 post-pop fault
        logic        warn;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{32'hFFFF_FFF8, 1'b1, 9'd5,  2'b01, 1'b0, 9'd0, 1'b0, 2'd0, 1'b0}, // thread main ok
        '{32'hFFFF_FFFC, 1'b1, 9'd11, 2'b01, 1'b0, 9'd0, 1'b1, 2'd0, 1'b0}, // thread proc, aligned
        '{32'hFFFF_FFF0, 1'b1, 9'd12, 2'b00, 1'b0, 9'd3, 1'b0, 2'd0, 1'b0}, // handler ok
        '{32'hFFFF_FFF0, 1'b1, 9'd12, 2'b01, 1'b0, 9'd0, 1'b0, 2'd2, 1'b0}, // handler, field 0
        '{32'hFFFF_FFF8, 1'b1, 9'd5,  2'b01, 1'b0, 9'd7, 1'b1, 2'd2, 1'b0}, // thread, field 7
        '{32'hFFFF_FFF8, 1'b1, 9'd5,  2'b11, 1'b0, 9'd0, 1'b0, 2'd1, 1'b0}, // not active
        '{32'hFFFF_FFF4, 1'b1, 9'd5,  2'b01, 1'b0, 9'd0, 1'b0, 2'd1, 1'b0}, // nibble 5
        '{32'hFFFF_FFF8, 1'b1, 9'd5,  2'b00, 1'b0, 9'd0, 1'b0, 2'd1, 1'b0}, // nested thread
        '{32'hFFFF_FFF8, 1'b1, 9'd5,  2'b00, 1'b1, 9'd0, 1'b0, 2'd0, 1'b0}, // nested, enabled
        '{32'hFFFF_FFF8, 1'b0, 9'd5,  2'b01, 1'b0, 9'd0, 1'b0, 2'd1, 1'b0}, // R1: isa 0 -> nibble 8
        '{32'h0000_00F8, 1'b1, 9'd5,  2'b01, 1'b0, 9'd0, 1'b0, 2'd0, 1'b1}, // high bits low
        '{32'hFFFF_FFFC, 1'b1, 9'd2,  2'b01, 1'b0, 9'd0, 1'b0, 2'd0, 1'b0}, // NMI exit
        '{32'hFFFF_FFF0, 1'b1, 9'd3,  2'b10, 1'b0, 9'd1, 1'b0, 2'd1, 1'b0}  // nest code 10
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ret_req = 1'b0;
    logic [31:0] ret_target = '0;
    logic        isa_flag = 1'b0;
    logic [8:0]  cur_exc = '0;
    logic [1:0]  nest_status = '0;
    logic        nonbase_thread_en = 1'b0;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        mem_req, reg_we, sp_we, sp_proc_sel, faultmask_clr, hibits_warn;
    logic        ret_done, ret_fault, fault_new_frame, invpc_set, usage_pend;
    logic [31:0] mem_addr, reg_wdata, sp_wdata, link_value;
    logic [2:0]  reg_idx;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    exc_return_unit i_exc_return_unit (
        .clk(clk), .rst_n(rst_n), .ret_req(ret_req), .ret_target(ret_target),
        .isa_flag(isa_flag), .cur_exc(cur_exc), .nest_status(nest_status),
        .nonbase_thread_en(nonbase_thread_en), .msp_in(MSP), .psp_in(PSP),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .reg_we(reg_we), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .sp_we(sp_we), .sp_proc_sel(sp_proc_sel),
        .sp_wdata(sp_wdata), .faultmask_clr(faultmask_clr),
        .hibits_warn(hibits_warn), .ret_done(ret_done), .ret_fault(ret_fault),
        .fault_new_frame(fault_new_frame), .invpc_set(invpc_set),
        .usage_pend(usage_pend), .link_value(link_value)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    task automatic run_vec(input int n);
        vec_t        v = VECS[n];
        logic [31:0] code = v.tgt | {31'b0, v.isa};
        logic        proc = (code[3:0] == 4'hD);
        logic [31:0] base = proc ? PSP : MSP;
        logic [31:0] xw   = {22'b0, v.align, v.field};
        logic [31:0] link = '0;
        logic [31:0] spv  = '0;
        logic [1:0]  kind = 2'd3;
        bit pend = 0, fm_seen = 0, warn_seen = 0, sp_seen = 0, sel = 0;
        bit newf = 0, inv = 0, up = 0, finished = 0;
        int pops = 0, outcomes = 0;
        @(negedge clk);
        ret_target = v.tgt; isa_flag = v.isa; cur_exc = v.exc;
        nest_status = v.nest; nonbase_thread_en = v.en; ret_req = 1'b1;
        for (int c = 0; c < 60 && !finished; c++) begin
            @(negedge clk);
            ret_req    = 1'b0;
            mem_rvalid = pend;
            mem_rdata  = (pops == 7) ? xw : 32'hC0DE_0000 + 32'(n * 256 + pops);
            #1;
            if (faultmask_clr) fm_seen = 1;
            if (hibits_warn)   warn_seen = 1;
            if (mem_req)
                chk(mem_addr == base + 32'(4 * pops), "R8 read address", mem_addr, base + 32'(4 * pops));
            if (reg_we) begin
                chk(reg_idx == 3'(pops), "R8 pop order", 32'(reg_idx), 32'(pops));
                chk(reg_wdata == mem_rdata, "R8 restored word", reg_wdata, mem_rdata);
                pops++;
            end
            if (sp_we) begin
                sp_seen = 1; spv = sp_wdata; sel = sp_proc_sel;
            end
            if (ret_done || ret_fault) begin
                outcomes++;
                kind = ret_done ? 2'd0 : (fault_new_frame ? 2'd2 : 2'd1);
                newf = fault_new_frame; inv = invpc_set; up = usage_pend;
                link = link_value;
                finished = 1;
            end
            pend = mem_req;
        end
        mem_rvalid = 1'b0;
        for (int c = 0; c < 2; c++) begin
            @(negedge clk); #1;
            if (ret_done || ret_fault) outcomes++;
        end
        chk(kind == v.kind, $sformatf("R4/R5/R6/R10 outcome row %0d", n), 32'(kind), 32'(v.kind));
        chk(outcomes == 1, "R11 single outcome pulse", 32'(outcomes), 32'd1);
        chk(warn_seen == v.warn, "R2 high-bit diagnostic", 32'(warn_seen), 32'(v.warn));
        chk(fm_seen == (v.exc != 9'd2), "R3 fault mask clear", 32'(fm_seen), 32'(v.exc != 9'd2));
        chk(pops == ((v.kind == 2'd1) ? 0 : 8), "R7/R8 words popped", 32'(pops), (v.kind == 2'd1) ? 32'd0 : 32'd8);
        if (v.kind != 2'd0) begin
            chk(link == (code | 32'hF000_0000), "R7 link value", link, code | 32'hF000_0000);
            chk(inv && up, "R7 invpc and usage pend", {30'b0, inv, up}, 32'd3);
            chk(newf == (v.kind == 2'd2), "R10 new frame flag", 32'(newf), 32'(v.kind == 2'd2));
        end
        if (v.kind != 2'd1) begin
            chk(sp_seen && spv == ((base + 32'd32) | (v.align ? 32'd4 : 32'd0)), "R9 restored sp",
                spv, (base + 32'd32) | (v.align ? 32'd4 : 32'd0));
            chk(sel == proc, "R5 stack select", 32'(sel), 32'(proc));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        // R12: reset state
        repeat (3) @(negedge clk);
        #1;
        chk(!(mem_req || ret_done || ret_fault || reg_we || sp_we), "R12 outputs in reset",
            {27'b0, mem_req, ret_done, ret_fault, reg_we, sp_we}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(!(mem_req || ret_done || ret_fault || faultmask_clr), "R12 idle after reset",
            {28'b0, mem_req, ret_done, ret_fault, faultmask_clr}, 32'd0);

        for (int n = 0; n < NV; n++) run_vec(n);

        // R12: reset in the middle of a pop, memory never answers
        @(negedge clk);
        ret_target = 32'hFFFF_FFF8; isa_flag = 1'b1; cur_exc = 9'd5;
        nest_status = 2'b01; nonbase_thread_en = 1'b0; ret_req = 1'b1;
        @(negedge clk); ret_req = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk); #1;
        chk(!(mem_req || ret_done || ret_fault), "R12 mid-pop reset",
            {29'b0, mem_req, ret_done, ret_fault}, 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk); #1;
        chk(!(mem_req || ret_done || ret_fault), "R12 idle after mid-pop reset",
            {29'b0, mem_req, ret_done, ret_fault}, 32'd0);
        run_vec(0);

        summary();
        $finish;
    end

endmodule